// File: doc/BRIEF.md
# Slow-Tick Register Write Synchroniser

This block accepts host writes on a fast register bus and delivers them to a set of registers that belong to a slow time base. Time, alarm, stopwatch, interrupt enable and prescaler registers are all synchronised. A write aimed at one of them goes into a single holding slot and is flagged as outstanding. The held value reaches its register only when the next slow commit tick arrives. At that moment the outstanding flag drops and a completion flag rises. The completion flag can drive an interrupt line.

The commit tick comes from a free-running input strobe at the fast sub-second rate (32.768 kHz in the target use). When the committed prescaler bit is on, the tick is divided down to one commit per `DIV` strobes, which gives 1 Hz for the default value. When that bit is off, every strobe is a commit point. Only one write can be outstanding at a time, and any synchronised write that arrives while the slot is full is thrown away. Writes to the status register do not go through the slot and take effect on the next clock edge. Software uses the status register to acknowledge completion.

Top module: `rtc_wsync_top`

## Requirements
- R1: After reset, the time, alarm, stopwatch and enable outputs are zero. The prescaler output is 1. Status bits 15 (complete) and 14 (outstanding) are 0, and the interrupt is low.
- R2: A write with address 0 (time), 1 (alarm), 2 (stopwatch), 3 (enable mask, low 16 data bits) or 4 (prescaler, data bit 0) is accepted when nothing is outstanding. Status bit 14 is 1 from the clock after acceptance until the commit.
- R3: A committed register changes only on a clock where a commit tick occurs with a write outstanding. Until then it keeps its old value.
- R4: While a write is outstanding, any other write to addresses 0 to 4 is discarded. The value and address of the first write are the ones committed.
- R5: When the prescaler output is 1, a commit tick occurs on every `DIV`-th strobe of `tick_in`, counted from reset or from the prescaler being turned on. When it is 0, every strobe is a commit tick.
- R6: A write to address 5 (status) with data bit 15 set clears the complete flag on the next clock. It never sets status bit 14, and it is accepted while a write is outstanding.
- R7: `irq_o` is high exactly when status bit 15 and enable-mask bit 15 are both 1.
- R8: On the commit clock, the register update, the clearing of bit 14 and the setting of bit 15 all appear together. If a status clear lands on that same clock, the set wins.
- R9: Writes to addresses 6 and 7 change no register and no flag.
- R10: A write accepted on a clock that also carries a commit tick is not committed by that tick. It waits for the next commit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write register address |
| wr_data | input | DATA_W | Host write data |
| tick_in | input | 1 | One-cycle strobe at the undivided slow rate |
| time_o | output | DATA_W | Committed time register |
| alarm_o | output | DATA_W | Committed alarm register |
| swatch_o | output | DATA_W | Committed stopwatch register |
| irqen_o | output | 16 | Committed interrupt enable mask |
| prescale_o | output | 1 | Committed prescaler enable |
| stat_o | output | 16 | Status: bit 15 complete, bit 14 outstanding |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench targets several timing corner cases, and each one has its own wrong result:
- A write sent while the slot is busy. A design that queues or overwrites it would commit the second value instead of the first.
- A write arriving on the same clock as a commit tick. A design that commits it at once would show the new value one tick early.
- A status clear that coincides with a commit. A design that gives the clear priority would lose the completion flag.
- Prescaler counting, checked both before and after the prescaler bit itself is committed off. A miscounting divider shifts every commit by whole strobes.

// File: rtl/rtc_wsync_pkg.sv
package rtc_wsync_pkg;
  localparam int ADDR_W   = 3;
  localparam int STAT_W   = 16;
  localparam int DONE_BIT = 15;
  localparam int PEND_BIT = 14;

  typedef enum logic [ADDR_W-1:0] {
    A_TIME     = 3'd0,
    A_ALARM    = 3'd1,
    A_SWATCH   = 3'd2,
    A_IRQEN    = 3'd3,
    A_PRESCALE = 3'd4,
    A_STATUS   = 3'd5
  } reg_addr_e;

  function automatic logic is_sync(input logic [ADDR_W-1:0] a);
    return a <= A_PRESCALE;
  endfunction
endpackage

// File: rtl/rtc_commit_tick.sv
module rtc_commit_tick #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic pre_en,
  output logic commit_o
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap     = (cnt_q == CNT_W'(DIV - 1));
  assign commit_o = tick_in & (~pre_en | wrap);

  always_comb begin
    cnt_d = cnt_q;
    if (!pre_en)      cnt_d = '0;
    else if (tick_in) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_write_slot.sv
module rtc_write_slot
  import rtc_wsync_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic              pend_o,
  output logic              apply_o,
  output logic [ADDR_W-1:0] slot_addr_o,
  output logic [DATA_W-1:0] slot_data_o
);
  logic              pend_q, pend_d;
  logic              capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign capture = wr_en & is_sync(wr_addr) & ~pend_q;
  assign apply_o = pend_q & commit;

  always_comb begin
    pend_d = pend_q;
    if (capture)      pend_d = 1'b1;
    else if (apply_o) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign pend_o      = pend_q;
  assign slot_addr_o = addr_q;
  assign slot_data_o = data_q;
endmodule

// File: rtl/rtc_commit_regs.sv
module rtc_commit_regs
  import rtc_wsync_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [DATA_W-1:0] slot_data,
  input  logic              done_clr,
  output logic [DATA_W-1:0] time_o,
  output logic [DATA_W-1:0] alarm_o,
  output logic [DATA_W-1:0] swatch_o,
  output logic [STAT_W-1:0] irqen_o,
  output logic              prescale_o,
  output logic              done_o
);
  logic [DATA_W-1:0] time_q, alarm_q, swatch_q;
  logic [DATA_W-1:0] time_d, alarm_d, swatch_d;
  logic [STAT_W-1:0] irqen_q, irqen_d;
  logic              pre_q, pre_d, done_q, done_d;

  always_comb begin
    time_d   = time_q;
    alarm_d  = alarm_q;
    swatch_d = swatch_q;
    irqen_d  = irqen_q;
    pre_d    = pre_q;
    if (apply) begin
      case (slot_addr)
        A_TIME:     time_d   = slot_data;
        A_ALARM:    alarm_d  = slot_data;
        A_SWATCH:   swatch_d = slot_data;
        A_IRQEN:    irqen_d  = slot_data[STAT_W-1:0];
        A_PRESCALE: pre_d    = slot_data[0];
        default:    ;
      endcase
    end
    done_d = done_q;
    if (apply)         done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      alarm_q  <= '0;
      swatch_q <= '0;
      irqen_q  <= '0;
      pre_q    <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      time_q   <= time_d;
      alarm_q  <= alarm_d;
      swatch_q <= swatch_d;
      irqen_q  <= irqen_d;
      pre_q    <= pre_d;
      done_q   <= done_d;
    end
  end

  assign time_o     = time_q;
  assign alarm_o    = alarm_q;
  assign swatch_o   = swatch_q;
  assign irqen_o    = irqen_q;
  assign prescale_o = pre_q;
  assign done_o     = done_q;
endmodule

// File: rtl/rtc_wsync_top.sv
module rtc_wsync_top
  import rtc_wsync_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV    = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_in,
  output logic [DATA_W-1:0] time_o,
  output logic [DATA_W-1:0] alarm_o,
  output logic [DATA_W-1:0] swatch_o,
  output logic [15:0]       irqen_o,
  output logic              prescale_o,
  output logic [15:0]       stat_o,
  output logic              irq_o
);
  logic              commit, pend, apply, done, done_clr;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_data;

  assign done_clr = wr_en & (wr_addr == A_STATUS) & wr_data[DONE_BIT];

  rtc_commit_tick #(.DIV(DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
    .pre_en(prescale_o), .commit_o(commit)
  );

  rtc_write_slot #(.DATA_W(DATA_W)) i_slot (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .pend_o(pend), .apply_o(apply),
    .slot_addr_o(slot_addr), .slot_data_o(slot_data)
  );

  rtc_commit_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .apply(apply), .slot_addr(slot_addr),
    .slot_data(slot_data), .done_clr(done_clr), .time_o(time_o),
    .alarm_o(alarm_o), .swatch_o(swatch_o), .irqen_o(irqen_o),
    .prescale_o(prescale_o), .done_o(done)
  );

  always_comb begin
    stat_o           = '0;
    stat_o[DONE_BIT] = done;
    stat_o[PEND_BIT] = pend;
  end

  assign irq_o = done & irqen_o[DONE_BIT];
endmodule

// File: rtl/rtc_wsync_checker.sv
module rtc_wsync_checker
  import rtc_wsync_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick_in,
  input logic [DATA_W-1:0] time_o,
  input logic [DATA_W-1:0] alarm_o,
  input logic [15:0]       stat_o,
  input logic [15:0]       irqen_o,
  input logic              irq_o
);
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && is_sync(wr_addr) && !stat_o[PEND_BIT] |=> stat_o[PEND_BIT]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> $stable(time_o) && $stable(alarm_o));

  p_keep_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[PEND_BIT] && !tick_in |=> stat_o[PEND_BIT]);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_STATUS && wr_data[DONE_BIT] && !tick_in
    |=> !stat_o[DONE_BIT]);

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (stat_o[DONE_BIT] && irqen_o[DONE_BIT]));

  p_done_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o[PEND_BIT]) |-> stat_o[DONE_BIT]);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr > A_STATUS && !stat_o[PEND_BIT] |=> !stat_o[PEND_BIT]);
endmodule

bind rtc_wsync_top rtc_wsync_checker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick_in(tick_in), .time_o(time_o), .alarm_o(alarm_o),
  .stat_o(stat_o), .irqen_o(irqen_o), .irq_o(irq_o)
);

// File: tb/test_rtc_wsync_top.sv
module test_rtc_wsync_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int DIV        = 4;

  logic              clk, rst_n, wr_en, tick_in;
  logic [2:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] time_o, alarm_o, swatch_o;
  logic [15:0]       irqen_o, stat_o;
  logic              prescale_o, irq_o;

  int checks = 0, errors = 0, cyc = 0;

  logic [DATA_W-1:0] m_time, m_alarm, m_swatch, m_data;
  logic [15:0]       m_irqen;
  logic              m_pre, m_pend, m_done;
  logic [2:0]        m_addr;
  int                m_cnt;

  rtc_wsync_top #(.DATA_W(DATA_W), .DIV(DIV)) i_rtc_wsync_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_in(tick_in), .time_o(time_o),
    .alarm_o(alarm_o), .swatch_o(swatch_o), .irqen_o(irqen_o),
    .prescale_o(prescale_o), .stat_o(stat_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic commit_due(input logic tk);
    return tk && (!m_pre || m_cnt == DIV - 1);
  endfunction

  task automatic model_reset();
    m_time = '0; m_alarm = '0; m_swatch = '0; m_irqen = '0;
    m_pre = 1'b1; m_pend = 1'b0; m_done = 1'b0; m_cnt = 0;
    m_addr = '0; m_data = '0;
  endtask

  task automatic model_step(input logic we, input logic [2:0] a,
                            input logic [DATA_W-1:0] d, input logic tk);
    logic cm, set_done, old_pre;
    cm = commit_due(tk);
    old_pre = m_pre;
    set_done = 1'b0;
    if (m_pend) begin
      if (cm) begin
        case (m_addr)
          3'd0: m_time = m_data;
          3'd1: m_alarm = m_data;
          3'd2: m_swatch = m_data;
          3'd3: m_irqen = m_data[15:0];
          default: m_pre = m_data[0];
        endcase
        m_pend = 1'b0;
        set_done = 1'b1;
      end
    end else if (we && a <= 3'd4) begin
      m_pend = 1'b1; m_addr = a; m_data = d;
    end
    if (set_done) m_done = 1'b1;
    else if (we && a == 3'd5 && d[15]) m_done = 1'b0;
    if (!old_pre) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
  endtask

  task automatic chk(input string tag, input string fld,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, "/R3"}, "time", time_o, m_time);
    chk({tag, "/R3"}, "alarm", alarm_o, m_alarm);
    chk({tag, "/R3"}, "swatch", swatch_o, m_swatch);
    chk({tag, "/R3"}, "irqen", DATA_W'(irqen_o), DATA_W'(m_irqen));
    chk({tag, "/R5"}, "prescale", DATA_W'(prescale_o), DATA_W'(m_pre));
    chk({tag, "/R2"}, "pend", DATA_W'(stat_o[14]), DATA_W'(m_pend));
    chk({tag, "/R6"}, "done", DATA_W'(stat_o[15]), DATA_W'(m_done));
    chk({tag, "/R7"}, "irq", DATA_W'(irq_o), DATA_W'(m_done & m_irqen[15]));
  endtask

  task automatic step(input logic we, input logic [2:0] a,
                      input logic [DATA_W-1:0] d, input logic tk, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick_in = tk;
    model_step(we, a, d, tk);
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5EED_0042);
    wr_en = 0; wr_addr = 0; wr_data = 0; tick_in = 0; rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    @(negedge clk) rst_n = 1;

    step(1, 3'd0, 32'h11, 0, "R2");
    step(1, 3'd0, 32'h22, 0, "R4");
    step(1, 3'd1, 32'h33, 0, "R4");
    step(0, 3'd0, 0, 1, "R5");
    step(0, 3'd0, 0, 1, "R5");
    step(0, 3'd0, 0, 1, "R5");
    step(0, 3'd0, 0, 1, "R8");
    step(1, 3'd5, 32'h8000, 0, "R6");
    step(1, 3'd3, 32'h8000, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 1, "R7");
    step(1, 3'd5, 32'h8000, 0, "R7");
    step(1, 3'd4, 32'h0, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 1, "R5");
    step(1, 3'd1, 32'hA5A5, 1, "R10");
    step(0, 3'd0, 0, 0, "R10");
    step(0, 3'd0, 0, 1, "R10");
    step(1, 3'd2, 32'h77, 0, "R8");
    step(1, 3'd5, 32'h8000, 1, "R8");
    step(1, 3'd6, 32'hFF, 0, "R9");
    step(1, 3'd7, 32'hFF, 1, "R9");
    step(1, 3'd5, 32'h4000, 0, "R6");

    for (int i = 0; i < 1500; i++) begin
      logic           we, tk;
      logic [2:0]     a;
      logic [DATA_W-1:0] d;
      we = ($urandom % 3) == 0;
      tk = ($urandom % 3) == 0;
      a  = 3'($urandom % 8);
      d  = $urandom;
      step(we, a, d, tk, "RND");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule